// File: doc/BRIEF.md
# Run-time Configurable Dual-Topology LFSR

This block is an N-bit linear feedback shift register. Everything that fixes its sequence is chosen while it runs: the tap coefficient vector, the stepping topology and the feedback polarity. In external-feedback (Fibonacci) stepping, the tapped bits are folded into one bit that enters at the top. In internal-feedback (Galois) stepping, the register shifts right and the tapped positions flip when the bit leaving the bottom calls for it. An XNOR option complements the feedback, and that moves the stuck (lock-up) state from all zeros to all ones.

A seed of the same width as the tap vector is written with a one-cycle load strobe. A step enable advances the register one position per clock. The rightmost bit is presented as the serial output, and the whole state is visible as well. A flag reports when the register sits in the lock-up word of the selected polarity. If software asks for the lock-up word as a seed, the block loads a safe neighbour of that word instead and raises a sticky warning.

Top module: `lfsr_dual`

## Requirements
- R1: While reset is asserted and after it is released, the state is 1 (only bit 0 set). The lock-up flag and the warning flag are low.
- R2: When load_i is high at a clock edge, the state takes the seed at that edge, whatever step_i is. The new value is visible on state_o after that edge.
- R3: With load_i and step_i both low, the state does not change.
- R4: With galois_i=0 and xnor_i=0, a step gives the new state {f, s[N-1:1]}, where f is the parity of (s AND taps).
- R5: With galois_i=1 and xnor_i=0, a step shifts right with 0 entering bit N-1. When the old bit 0 was 1, every bit position whose tap bit is 1 is also inverted.
- R6: With xnor_i=1 the feedback is complemented. In external-feedback stepping, f is the inverted parity. In internal-feedback stepping, 1 enters bit N-1 and the tapped positions are inverted when the old bit 0 was 0.
- R7: serial_o always equals bit 0 of state_o.
- R8: lockup_o is high exactly when state_o equals the lock-up word of the current polarity: all zeros for xnor_i=0, all ones for xnor_i=1.
- R9: The lock-up word is absorbing. A step leaves it unchanged in both topologies for XOR feedback, and for XNOR feedback in internal-feedback stepping or with an even number of taps.
- R10: Loading a seed equal to the current lock-up word stores that word with bit 0 inverted.
- R11: seed_warn_o rises after a lock-up seed is loaded and stays high through steps until the next load of any other seed, which clears it.
- R12: At N=4 with taps 4'b0011 (external feedback) or 4'b1100 (internal feedback), in either polarity, the register returns to its seed after exactly 15 steps and passes through every non-lock-up state once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write seed_i into the register |
| seed_i | input | WIDTH | Seed value |
| step_i | input | 1 | Advance one position |
| taps_i | input | WIDTH | Tap coefficient vector, 1 = position feeds back |
| galois_i | input | 1 | 0 = external feedback, 1 = internal feedback |
| xnor_i | input | 1 | 0 = XOR feedback, 1 = XNOR feedback |
| state_o | output | WIDTH | Current register contents |
| serial_o | output | 1 | Rightmost state bit |
| lockup_o | output | 1 | State equals lock-up word of current polarity |
| seed_warn_o | output | 1 | Sticky: last load requested the lock-up word |

## Verification
A load and a step can arrive in the same cycle. A lock-up seed load can also coincide with a step while the warning flag is already set. The bench raises load_i and step_i together at several points in a running sequence: with clean seeds, with lock-up seeds, and in both topologies. The cycle-accurate reference model gives the load precedence. The state, warning flag and lock-up flag after that edge are compared against it, and a stray step would show up as a shifted seed.

// File: rtl/lfsr_dual_pkg.sv
package lfsr_dual_pkg;
  typedef enum logic {TOPO_FIB = 1'b0, TOPO_GAL = 1'b1} topo_e;
  typedef enum logic {POL_XOR = 1'b0, POL_XNOR = 1'b1} pol_e;
endpackage

// File: rtl/lfsr_fib_step.sv
module lfsr_fib_step #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] taps_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] next_o
);
  logic [WIDTH-1:0] masked;
  logic             fb;

  assign masked = state_i & taps_i;
  assign fb     = (^masked) ^ inv_i;
  assign next_o = {fb, state_i[WIDTH-1:1]};
endmodule

// File: rtl/lfsr_gal_step.sv
module lfsr_gal_step #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] taps_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] next_o
);
  logic fire;

  // xnor form is the complement image of the xor form
  assign fire = state_i[0] ^ inv_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      assign next_o[i] = inv_i ^ (fire & taps_i[i]);
    end else begin : g_mid
      assign next_o[i] = state_i[i+1] ^ (fire & taps_i[i]);
    end
  end
endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] lock_i,
  output logic [WIDTH-1:0] seed_o,
  output logic             hit_o
);
  localparam logic [WIDTH-1:0] LsbOnly = WIDTH'(1);

  assign hit_o  = (seed_i == lock_i);
  assign seed_o = hit_o ? (lock_i ^ LsbOnly) : seed_i;
endmodule

// File: rtl/lfsr_dual.sv
module lfsr_dual
  import lfsr_dual_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] taps_i,
  input  logic             galois_i,
  input  logic             xnor_i,
  output logic [WIDTH-1:0] state_o,
  output logic             serial_o,
  output logic             lockup_o,
  output logic             seed_warn_o
);
  localparam logic [WIDTH-1:0] ResetWord = WIDTH'(1);

  topo_e            topo;
  pol_e             pol;
  logic [WIDTH-1:0] lock_word;
  logic [WIDTH-1:0] state_q, state_d;
  logic [WIDTH-1:0] fib_next, gal_next, safe_seed;
  logic             seed_hit;
  logic             warn_q, warn_d;

  assign topo      = topo_e'(galois_i);
  assign pol       = pol_e'(xnor_i);
  assign lock_word = {WIDTH{pol == POL_XNOR}};

  lfsr_fib_step #(.WIDTH(WIDTH)) fib_i (
    .state_i(state_q), .taps_i(taps_i), .inv_i(pol == POL_XNOR), .next_o(fib_next)
  );

  lfsr_gal_step #(.WIDTH(WIDTH)) gal_i (
    .state_i(state_q), .taps_i(taps_i), .inv_i(pol == POL_XNOR), .next_o(gal_next)
  );

  lfsr_seed_guard #(.WIDTH(WIDTH)) guard_i (
    .seed_i(seed_i), .lock_i(lock_word), .seed_o(safe_seed), .hit_o(seed_hit)
  );

  always_comb begin
    state_d = state_q;
    warn_d  = warn_q;
    if (load_i) begin
      state_d = safe_seed;
      warn_d  = seed_hit;
    end else if (step_i) begin
      state_d = (topo == TOPO_GAL) ? gal_next : fib_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ResetWord;
      warn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      warn_q  <= warn_d;
    end
  end

  assign state_o     = state_q;
  assign serial_o    = state_q[0];
  assign lockup_o    = (state_q == lock_word);
  assign seed_warn_o = warn_q;
endmodule

// File: rtl/lfsr_dual_chk.sv
module lfsr_dual_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [WIDTH-1:0] seed_i,
  input logic             step_i,
  input logic [WIDTH-1:0] taps_i,
  input logic             galois_i,
  input logic             xnor_i,
  input logic [WIDTH-1:0] state_o,
  input logic             serial_o,
  input logic             lockup_o,
  input logic             seed_warn_o
);
  // R2
  clean_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i != {WIDTH{xnor_i}}) |=> (state_o == $past(seed_i) && !seed_warn_o));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(state_o));

  // R4
  fib_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !galois_i) |=> (state_o[WIDTH-2:0] == $past(state_o[WIDTH-1:1])));

  // R9
  absorb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && lockup_o && (!xnor_i || galois_i))
      |=> ((xnor_i != $past(xnor_i)) || lockup_o));

  // R10
  lock_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == {WIDTH{xnor_i}}) |=> (seed_warn_o && (state_o ^ $past(seed_i)) == WIDTH'(1)));

  // R11
  warn_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_warn_o && !load_i) |=> seed_warn_o);
endmodule

bind lfsr_dual lfsr_dual_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .seed_i(seed_i), .step_i(step_i),
  .taps_i(taps_i), .galois_i(galois_i), .xnor_i(xnor_i), .state_o(state_o),
  .serial_o(serial_o), .lockup_o(lockup_o), .seed_warn_o(seed_warn_o)
);

// File: tb/lfsr_dual_tb_top.sv
module lfsr_dual_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0, step = 1'b0, gal = 1'b0, xn = 1'b0;
  logic [W-1:0] seed = '0, taps = '0;
  logic [W-1:0] state;
  logic         serial, lockup, warn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0] m_state;
  logic         m_warn;

  always #2 clk = ~clk;

  lfsr_dual #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed_i(seed), .step_i(step),
    .taps_i(taps), .galois_i(gal), .xnor_i(xn), .state_o(state),
    .serial_o(serial), .lockup_o(lockup), .seed_warn_o(warn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lock_of(input logic x);
    return x ? {W{1'b1}} : {W{1'b0}};
  endfunction

  // behavioural reference step
  function automatic logic [W-1:0] ref_next(input logic [W-1:0] s);
    logic [W-1:0] n;
    int ones = 0;
    if (!gal) begin
      for (int i = 0; i < W; i++) if (s[i] && taps[i]) ones++;
      n = s >> 1;
      n[W-1] = (ones % 2 == 1) ^ xn;
    end else begin
      n = s >> 1;
      if (xn) n[W-1] = 1'b1;
      if (s[0] != xn) n = n ^ taps;
    end
    return n;
  endfunction

  task automatic cmp_all(input string tag);
    chk({tag, " R2/R4/R5/R6 state"}, int'(state), int'(m_state));
    chk({tag, " R7 serial"}, int'(serial), int'(m_state[0]));
    chk({tag, " R8 lockup"}, int'(lockup), int'(m_state == lock_of(xn)));
    chk({tag, " R11 warn"}, int'(warn), int'(m_warn));
  endtask

  task automatic cyc(input logic ld, input logic [W-1:0] sd, input logic st, input string tag);
    @(negedge clk);
    load = ld; seed = sd; step = st;
    if (ld) begin
      if (sd == lock_of(xn)) begin m_state = lock_of(xn) ^ W'(1); m_warn = 1'b1; end
      else begin m_state = sd; m_warn = 1'b0; end
    end else if (st) begin
      m_state = ref_next(m_state);
    end
    @(posedge clk); #1;
    cmp_all(tag);
  endtask

  task automatic set_mode(input logic g, input logic x, input logic [W-1:0] t);
    @(negedge clk);
    gal = g; xn = x; taps = t; load = 1'b0; step = 1'b0;
    #1;
    cmp_all("mode");
  endtask

  task automatic run_period(input logic g, input logic x, input logic [W-1:0] t, input logic [W-1:0] sd);
    logic [15:0] vis = '0;
    int first_ret = 0;
    set_mode(g, x, t);
    cyc(1'b1, sd, 1'b0, "R12 seed");
    for (int k = 1; k <= 15; k++) begin
      cyc(1'b0, '0, 1'b1, "R12 walk");
      vis[state] = 1'b1;
      if (state == sd && first_ret == 0) first_ret = k;
    end
    chk("R12 period", first_ret, 15);
    chk("R12 coverage", $countones(vis), 15);
    chk("R12 lockup unvisited", int'(vis[lock_of(x)]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_state = W'(1); m_warn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during and after reset
    chk("R1 state in reset", int'(state), 1);
    chk("R1 lockup in reset", int'(lockup), 0);
    chk("R1 warn in reset", int'(warn), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    cmp_all("R1 after reset");

    // R4/R5/R6 and R3 under varied patterns
    set_mode(1'b0, 1'b0, 4'b0011);
    for (int k = 0; k < 6; k++) cyc(1'b0, '0, 1'b1, "R4 fib xor");
    cyc(1'b0, '0, 1'b0, "R3 hold");
    cyc(1'b0, '0, 1'b0, "R3 hold");
    set_mode(1'b1, 1'b0, 4'b1011);
    cyc(1'b1, 4'b1001, 1'b0, "R5 seed");
    for (int k = 0; k < 6; k++) cyc(1'b0, '0, 1'b1, "R5 gal xor");
    set_mode(1'b0, 1'b1, 4'b0110);
    for (int k = 0; k < 5; k++) cyc(1'b0, '0, 1'b1, "R6 fib xnor");
    set_mode(1'b1, 1'b1, 4'b0101);
    for (int k = 0; k < 5; k++) cyc(1'b0, '0, 1'b1, "R6 gal xnor");

    // R2 load and step together
    set_mode(1'b0, 1'b0, 4'b0011);
    cyc(1'b1, 4'b1010, 1'b1, "R2 load+step fib");
    chk("R2 load wins", int'(state), 10);
    set_mode(1'b1, 1'b0, 4'b1100);
    cyc(1'b1, 4'b0111, 1'b1, "R2 load+step gal");
    chk("R2 load wins gal", int'(state), 7);

    // R10/R11 lock-up seed handling, also with concurrent step
    cyc(1'b1, 4'b0000, 1'b1, "R10 xor lock seed");
    chk("R10 substituted", int'(state), 1);
    chk("R11 warn set", int'(warn), 1);
    for (int k = 0; k < 3; k++) cyc(1'b0, '0, 1'b1, "R11 sticky");
    cyc(1'b1, 4'b0000, 1'b1, "R11 lock seed while warned");
    cyc(1'b1, 4'b0101, 1'b0, "R11 clean load");
    chk("R11 warn cleared", int'(warn), 0);
    set_mode(1'b0, 1'b1, 4'b0011);
    cyc(1'b1, 4'b1111, 1'b0, "R10 xnor lock seed");
    chk("R10 xnor substituted", int'(state), 14);

    // R8/R9 reaching lock-up through polarity change
    set_mode(1'b1, 1'b0, 4'b1100);
    cyc(1'b1, 4'b1111, 1'b0, "R8 load ones xor");
    chk("R8 ones not lockup under xor", int'(lockup), 0);
    set_mode(1'b1, 1'b1, 4'b1100);
    chk("R8 ones lockup under xnor", int'(lockup), 1);
    for (int k = 0; k < 3; k++) cyc(1'b0, '0, 1'b1, "R9 gal xnor absorb");
    chk("R9 gal xnor stuck", int'(state), 15);
    set_mode(1'b0, 1'b1, 4'b0011);
    for (int k = 0; k < 2; k++) cyc(1'b0, '0, 1'b1, "R9 fib xnor absorb");
    chk("R9 fib xnor stuck", int'(state), 15);
    cyc(1'b1, 4'b0000, 1'b0, "R8 load zeros xnor");
    set_mode(1'b0, 1'b0, 4'b0011);
    chk("R8 zeros lockup under xor", int'(lockup), 1);
    for (int k = 0; k < 2; k++) cyc(1'b0, '0, 1'b1, "R9 fib xor absorb");
    set_mode(1'b1, 1'b0, 4'b1100);
    for (int k = 0; k < 2; k++) cyc(1'b0, '0, 1'b1, "R9 gal xor absorb");
    chk("R9 xor stuck", int'(state), 0);

    // R12 maximal length in all four combinations
    run_period(1'b0, 1'b0, 4'b0011, 4'b0001);
    run_period(1'b1, 1'b0, 4'b1100, 4'b1010);
    run_period(1'b0, 1'b1, 4'b0011, 4'b0110);
    run_period(1'b1, 1'b1, 4'b1100, 4'b1110);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule